// File: doc/BRIEF.md
# Register-Pair Load/Store Sequencer

This block carries out 64-bit loads and stores that move an even/odd pair of general registers on a core whose data path is 32 bits wide. An instruction word is offered with a valid/ready handshake. The block decodes it and reads the base register and the data register through two combinational register-file read ports. It then performs the access as two 32-bit word transactions, one after the other, on a simple request/response memory port. For a load, the two returned words go back to the register file in one pair-wide write.

Each word address is checked for 4-byte alignment before its request is issued. An illegal encoding, a misaligned word or a bus error ends the instruction with an exception. The exception carries a cause code and an address, and both stay on the outputs until the trap logic acknowledges them. If either word faults, no register is written. A load whose target is x0 finishes at once, with no memory traffic.

Top module: `pairmem_seq`

## Requirements
- R1: A pair load is decoded when bits 6:0 are 0000011 and bits 14:12 are 011. Its immediate is bits 31:20, its base register is bits 19:15 and its target register is bits 11:7. An instruction is taken only while `ins_ready` is high, and `ins_ready` is high only in the idle state.
- R2: A pair store is decoded when bits 6:0 are 0100011 and bits 14:12 are 011. Its immediate is {bits 31:25, bits 11:7}, its data register is bits 24:20 and its base register is bits 19:15.
- R3: Any of the following makes an accepted word illegal: an odd pair register, another opcode or funct3, `pair_en` low, or a data width other than 32. An illegal word completes with cause 2 and `exc_addr` equal to the instruction word, with no memory request and no register write.
- R4: The first word address is base + sext(imm). The second word address is base + sext((imm + 4) mod 4096), so the 12-bit sum wraps before sign extension.
- R5: A load that succeeds writes exactly once, in its completion cycle. The write carries `rf_wr_addr` = rd, `rf_wr_lo` = the first word and `rf_wr_hi` = the second word, and the high word goes to register rd+1.
- R6: A load whose target is x0 makes no memory request and no register write, and completes without an exception.
- R7: A store drives `mem_we` high and writes X(rs2) at the first address and X(rs2+1) at the second. When rs2 is x0, both words are zero.
- R8: A word whose address has bits 1:0 not equal to 00 issues no request. The instruction ends with cause 4 for a load or cause 6 for a store, and `exc_addr` is that word's address.
- R9: A response with `mem_rsp_err` high ends the instruction with cause 5 for a load or cause 7 for a store, and `exc_addr` is that word's address. A fault on the first word prevents the second request. A faulting instruction writes no register.
- R10: `busy` is high from the cycle after acceptance until completion. `exc_valid`, `exc_cause` and `exc_addr` hold their values until `exc_ack`, and the block returns to idle in the cycle after the acknowledge.
- R11: While a request waits for its response, `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pair_en | input | 1 | Enables the pair instructions |
| ins_valid | input | 1 | Instruction word offered |
| ins_ready | output | 1 | Block can take an instruction |
| ins_word | input | 32 | Instruction word |
| rf_ra_addr | output | 5 | Base register index |
| rf_ra_data | input | DATA_W | Base register value |
| rf_rb_addr | output | 5 | Data register index (rs2, then rs2+1) |
| rf_rb_data | input | DATA_W | Data register value |
| rf_wr_en | output | 1 | Pair write strobe |
| rf_wr_addr | output | 5 | Even register of the written pair |
| rf_wr_lo | output | DATA_W | Value for the even register |
| rf_wr_hi | output | DATA_W | Value for the odd register |
| mem_req | output | 1 | Word request pending |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | DATA_W | Word address |
| mem_wdata | output | DATA_W | Write data |
| mem_rsp_valid | input | 1 | Response for the pending request |
| mem_rsp_err | input | 1 | Response reports a bus error |
| mem_rdata | input | DATA_W | Read data |
| busy | output | 1 | Instruction in progress |
| cmp_valid | output | 1 | Completion cycle |
| exc_valid | output | 1 | Completion carries an exception |
| exc_cause | output | 4 | Exception cause code |
| exc_addr | output | DATA_W | Faulting address or illegal word |
| exc_ack | input | 1 | Trap logic acknowledges the exception |

## Verification
The assertions assume a memory that raises `mem_rsp_valid` only while a request is pending, and only once for that request. They also assume that `exc_ack` is driven only while an exception is shown, and that no instruction is offered during the reset-release cycles. The bench's memory model answers only a pending request, after a chosen wait of zero to two cycles. It pulses the acknowledge only after it has seen the exception and checked that the exception holds. It presents each instruction only in a cycle where `ins_ready` is high.

// File: rtl/pairmem_pkg.sv
package pairmem_pkg;

  localparam int REG_IDX_W = 5;
  localparam int CAUSE_W   = 4;
  localparam int IMM_W     = 12;

  localparam logic [6:0] OPC_LOAD    = 7'b0000011;
  localparam logic [6:0] OPC_STORE   = 7'b0100011;
  localparam logic [2:0] FUNCT3_PAIR = 3'b011;

  localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL   = 4'd2;
  localparam logic [CAUSE_W-1:0] CAUSE_LD_MISAL  = 4'd4;
  localparam logic [CAUSE_W-1:0] CAUSE_LD_FAULT  = 4'd5;
  localparam logic [CAUSE_W-1:0] CAUSE_ST_MISAL  = 4'd6;
  localparam logic [CAUSE_W-1:0] CAUSE_ST_FAULT  = 4'd7;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WORD0 = 2'd1,
    ST_WORD1 = 2'd2,
    ST_DONE  = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic                 legal;
    logic                 is_store;
    logic [REG_IDX_W-1:0] base_reg;
    logic [REG_IDX_W-1:0] pair_reg;
    logic [IMM_W-1:0]     imm;
  } pair_op_t;

endpackage

// File: rtl/pairmem_rst_sync.sv
module pairmem_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/pairmem_decode.sv
module pairmem_decode
  import pairmem_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [31:0] ins_word,
  input  logic        pair_en,
  output pair_op_t    op
);

  localparam logic WIDTH_OK = (DATA_W == 32) ? 1'b1 : 1'b0;

  logic [6:0] opcode;
  logic [2:0] funct3;
  logic       is_ld;
  logic       is_st;

  always_comb begin
    opcode = ins_word[6:0];
    funct3 = ins_word[14:12];
    is_ld  = (opcode == OPC_LOAD)  && (funct3 == FUNCT3_PAIR);
    is_st  = (opcode == OPC_STORE) && (funct3 == FUNCT3_PAIR);

    op.is_store = is_st;
    op.base_reg = ins_word[19:15];
    op.pair_reg = is_st ? ins_word[24:20] : ins_word[11:7];
    op.imm      = is_st ? {ins_word[31:25], ins_word[11:7]} : ins_word[31:20];
    op.legal    = pair_en && WIDTH_OK && (is_ld || is_st) && !op.pair_reg[0];
  end

endmodule

// File: rtl/pairmem_agen.sv
module pairmem_agen
  import pairmem_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] base,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] addr_lo,
  output logic [DATA_W-1:0] addr_hi,
  output logic              misal_lo,
  output logic              misal_hi
);

  localparam int WORD_BYTES = DATA_W / 8;
  localparam int ALIGN_W    = $clog2(WORD_BYTES);
  localparam int EXT_W      = DATA_W - IMM_W;

  logic [IMM_W-1:0]  imm_next;
  logic [DATA_W-1:0] off_lo;
  logic [DATA_W-1:0] off_hi;

  always_comb begin
    imm_next = imm + IMM_W'(WORD_BYTES);
    off_lo   = {{EXT_W{imm[IMM_W-1]}}, imm};
    off_hi   = {{EXT_W{imm_next[IMM_W-1]}}, imm_next};
    addr_lo  = base + off_lo;
    addr_hi  = base + off_hi;
    misal_lo = |addr_lo[ALIGN_W-1:0];
    misal_hi = |addr_hi[ALIGN_W-1:0];
  end

endmodule

// File: rtl/pairmem_ctrl.sv
module pairmem_ctrl
  import pairmem_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept,
  input  logic               dec_legal,
  input  logic               dec_skip,
  input  logic               is_store_q,
  input  logic               word_misal,
  input  logic               rsp_valid,
  input  logic               rsp_err,
  input  logic               exc_ack,
  input  logic               exc_pend,
  output seq_state_e         state_q,
  output logic               mem_req,
  output logic               exc_set,
  output logic [CAUSE_W-1:0] exc_cause_set,
  output logic               w0_ok,
  output logic               w1_ok
);

  seq_state_e state_nxt;

  always_comb begin
    state_nxt     = state_q;
    mem_req       = 1'b0;
    exc_set       = 1'b0;
    exc_cause_set = CAUSE_ILLEGAL;
    w0_ok         = 1'b0;
    w1_ok         = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (!dec_legal) begin
            exc_set   = 1'b1;
            state_nxt = ST_DONE;
          end else if (dec_skip) begin
            state_nxt = ST_DONE;
          end else begin
            state_nxt = ST_WORD0;
          end
        end
      end
      ST_WORD0, ST_WORD1: begin
        if (word_misal) begin
          exc_set       = 1'b1;
          exc_cause_set = is_store_q ? CAUSE_ST_MISAL : CAUSE_LD_MISAL;
          state_nxt     = ST_DONE;
        end else begin
          mem_req = 1'b1;
          if (rsp_valid) begin
            if (rsp_err) begin
              exc_set       = 1'b1;
              exc_cause_set = is_store_q ? CAUSE_ST_FAULT : CAUSE_LD_FAULT;
              state_nxt     = ST_DONE;
            end else if (state_q == ST_WORD0) begin
              w0_ok     = 1'b1;
              state_nxt = ST_WORD1;
            end else begin
              w1_ok     = 1'b1;
              state_nxt = ST_DONE;
            end
          end
        end
      end
      ST_DONE: begin
        if (!exc_pend || exc_ack) begin
          state_nxt = ST_IDLE;
        end
      end
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_nxt;
    end
  end

endmodule

// File: rtl/pairmem_seq.sv
module pairmem_seq
  import pairmem_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pair_en,
  input  logic                 ins_valid,
  output logic                 ins_ready,
  input  logic [31:0]          ins_word,
  output logic [REG_IDX_W-1:0] rf_ra_addr,
  input  logic [DATA_W-1:0]    rf_ra_data,
  output logic [REG_IDX_W-1:0] rf_rb_addr,
  input  logic [DATA_W-1:0]    rf_rb_data,
  output logic                 rf_wr_en,
  output logic [REG_IDX_W-1:0] rf_wr_addr,
  output logic [DATA_W-1:0]    rf_wr_lo,
  output logic [DATA_W-1:0]    rf_wr_hi,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [DATA_W-1:0]    mem_addr,
  output logic [DATA_W-1:0]    mem_wdata,
  input  logic                 mem_rsp_valid,
  input  logic                 mem_rsp_err,
  input  logic [DATA_W-1:0]    mem_rdata,
  output logic                 busy,
  output logic                 cmp_valid,
  output logic                 exc_valid,
  output logic [CAUSE_W-1:0]   exc_cause,
  output logic [DATA_W-1:0]    exc_addr,
  input  logic                 exc_ack
);

  logic                 rst_sync_n;
  seq_state_e           state_q;
  pair_op_t             dec;
  logic                 accept;
  logic                 dec_skip;
  logic                 exc_set;
  logic [CAUSE_W-1:0]   exc_cause_set;
  logic                 w0_ok;
  logic                 w1_ok;
  logic                 word_hi;
  logic                 word_misal;
  logic [DATA_W-1:0]    agen_lo;
  logic [DATA_W-1:0]    agen_hi;
  logic                 agen_misal_lo;
  logic                 agen_misal_hi;
  logic [DATA_W-1:0]    exc_addr_nxt;

  logic                 is_store_q;
  logic [REG_IDX_W-1:0] pair_q;
  logic [DATA_W-1:0]    addr_lo_q;
  logic [DATA_W-1:0]    addr_hi_q;
  logic                 misal_lo_q;
  logic                 misal_hi_q;
  logic [DATA_W-1:0]    wdata_lo_q;
  logic [DATA_W-1:0]    wdata_hi_q;
  logic [DATA_W-1:0]    rdata_lo_q;
  logic [DATA_W-1:0]    rdata_hi_q;
  logic                 exc_pend_q;
  logic [CAUSE_W-1:0]   exc_cause_q;
  logic [DATA_W-1:0]    exc_addr_q;

  pairmem_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pairmem_decode #(.DATA_W(DATA_W)) u_decode (
    .ins_word (ins_word),
    .pair_en  (pair_en),
    .op       (dec)
  );

  pairmem_agen #(.DATA_W(DATA_W)) u_agen (
    .base     (rf_ra_data),
    .imm      (dec.imm),
    .addr_lo  (agen_lo),
    .addr_hi  (agen_hi),
    .misal_lo (agen_misal_lo),
    .misal_hi (agen_misal_hi)
  );

  pairmem_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .accept        (accept),
    .dec_legal     (dec.legal),
    .dec_skip      (dec_skip),
    .is_store_q    (is_store_q),
    .word_misal    (word_misal),
    .rsp_valid     (mem_rsp_valid),
    .rsp_err       (mem_rsp_err),
    .exc_ack       (exc_ack),
    .exc_pend      (exc_pend_q),
    .state_q       (state_q),
    .mem_req       (mem_req),
    .exc_set       (exc_set),
    .exc_cause_set (exc_cause_set),
    .w0_ok         (w0_ok),
    .w1_ok         (w1_ok)
  );

  // Handshake and register-file read addressing
  always_comb begin
    ins_ready  = rst_sync_n && (state_q == ST_IDLE);
    accept     = ins_valid && ins_ready;
    dec_skip   = !dec.is_store && (dec.pair_reg == '0);
    rf_ra_addr = dec.base_reg;
    rf_rb_addr = (state_q == ST_IDLE) ? dec.pair_reg : (pair_q | REG_IDX_W'(1));
    word_hi    = (state_q == ST_WORD1);
    word_misal = word_hi ? misal_hi_q : misal_lo_q;
  end

  // Faulting address: instruction word when illegal, else the current word
  always_comb begin
    if (state_q == ST_IDLE) begin
      exc_addr_nxt = DATA_W'(ins_word);
    end else if (word_hi) begin
      exc_addr_nxt = addr_hi_q;
    end else begin
      exc_addr_nxt = addr_lo_q;
    end
  end

  // Instruction capture, enabled on accept
  always_ff @(posedge clk) begin
    if (accept) begin
      is_store_q <= dec.is_store;
      pair_q     <= dec.pair_reg;
      addr_lo_q  <= agen_lo;
      addr_hi_q  <= agen_hi;
      misal_lo_q <= agen_misal_lo;
      misal_hi_q <= agen_misal_hi;
      wdata_lo_q <= (dec.pair_reg == '0) ? '0 : rf_rb_data;
    end
  end

  // First word completion
  always_ff @(posedge clk) begin
    if (w0_ok) begin
      rdata_lo_q <= mem_rdata;
      wdata_hi_q <= (pair_q == '0) ? '0 : rf_rb_data;
    end
  end

  // Second word completion
  always_ff @(posedge clk) begin
    if (w1_ok) begin
      rdata_hi_q <= mem_rdata;
    end
  end

  // Exception pending flag
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      exc_pend_q <= 1'b0;
    end else if (exc_set) begin
      exc_pend_q <= 1'b1;
    end else if ((state_q == ST_DONE) && exc_ack) begin
      exc_pend_q <= 1'b0;
    end
  end

  // Exception payload, enabled on set
  always_ff @(posedge clk) begin
    if (exc_set) begin
      exc_cause_q <= exc_cause_set;
      exc_addr_q  <= exc_addr_nxt;
    end
  end

  // Outputs
  always_comb begin
    busy       = (state_q != ST_IDLE);
    cmp_valid  = (state_q == ST_DONE);
    exc_valid  = cmp_valid && exc_pend_q;
    exc_cause  = exc_cause_q;
    exc_addr   = exc_addr_q;
    mem_we     = is_store_q;
    mem_addr   = word_hi ? addr_hi_q : addr_lo_q;
    mem_wdata  = word_hi ? wdata_hi_q : wdata_lo_q;
    rf_wr_en   = cmp_valid && !exc_pend_q && !is_store_q && (pair_q != '0);
    rf_wr_addr = pair_q;
    rf_wr_lo   = rdata_lo_q;
    rf_wr_hi   = rdata_hi_q;
  end

endmodule

// File: rtl/pairmem_seq_chk.sv
module pairmem_seq_chk
  import pairmem_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ins_valid,
  input logic                 ins_ready,
  input logic                 busy,
  input logic                 mem_req,
  input logic                 mem_rsp_valid,
  input logic                 mem_we,
  input logic [DATA_W-1:0]    mem_addr,
  input logic [DATA_W-1:0]    mem_wdata,
  input logic                 exc_valid,
  input logic                 exc_ack,
  input logic [CAUSE_W-1:0]   exc_cause,
  input logic [DATA_W-1:0]    exc_addr,
  input logic                 rf_wr_en,
  input logic [REG_IDX_W-1:0] rf_wr_addr
);

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ins_ready |-> !mem_req); // R1

  AST_WR_EVEN_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_en |-> (!rf_wr_addr[0] && (rf_wr_addr != '0))); // R5

  AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00)); // R8

  AST_NO_WR_ON_EXC: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_en |-> !exc_valid); // R9

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_ready) |=> busy); // R10

  AST_EXC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && !exc_ack) |=> (exc_valid && $stable(exc_cause) && $stable(exc_addr))); // R10

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rsp_valid) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R11

endmodule

bind pairmem_seq pairmem_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ins_valid     (ins_valid),
  .ins_ready     (ins_ready),
  .busy          (busy),
  .mem_req       (mem_req),
  .mem_rsp_valid (mem_rsp_valid),
  .mem_we        (mem_we),
  .mem_addr      (mem_addr),
  .mem_wdata     (mem_wdata),
  .exc_valid     (exc_valid),
  .exc_ack       (exc_ack),
  .exc_cause     (exc_cause),
  .exc_addr      (exc_addr),
  .rf_wr_en      (rf_wr_en),
  .rf_wr_addr    (rf_wr_addr)
);

// File: tb/pairmem_seq_test.sv
module pairmem_seq_test;
  import pairmem_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        pair_en;
  logic        ins_valid;
  logic        ins_ready;
  logic [31:0] ins_word;
  logic [4:0]  rf_ra_addr;
  logic [31:0] rf_ra_data;
  logic [4:0]  rf_rb_addr;
  logic [31:0] rf_rb_data;
  logic        rf_wr_en;
  logic [4:0]  rf_wr_addr;
  logic [31:0] rf_wr_lo;
  logic [31:0] rf_wr_hi;
  logic        mem_req;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_rsp_valid;
  logic        mem_rsp_err;
  logic [31:0] mem_rdata;
  logic        busy;
  logic        cmp_valid;
  logic        exc_valid;
  logic [3:0]  exc_cause;
  logic [31:0] exc_addr;
  logic        exc_ack;

  int n_tests;
  int n_fail;

  int          lat;
  logic        err_on;
  logic [31:0] err_addr;
  int          wait_cnt;
  logic [31:0] hold_addr;
  logic [31:0] hold_wd;
  logic        hold_we;

  logic [31:0] tx_addr [4];
  logic [31:0] tx_wd   [4];
  logic        tx_we   [4];
  int          tx_n;
  int          wr_n;
  logic [4:0]  wr_a;
  logic [31:0] wr_lo;
  logic [31:0] wr_hi;

  pairmem_seq uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .pair_en       (pair_en),
    .ins_valid     (ins_valid),
    .ins_ready     (ins_ready),
    .ins_word      (ins_word),
    .rf_ra_addr    (rf_ra_addr),
    .rf_ra_data    (rf_ra_data),
    .rf_rb_addr    (rf_rb_addr),
    .rf_rb_data    (rf_rb_data),
    .rf_wr_en      (rf_wr_en),
    .rf_wr_addr    (rf_wr_addr),
    .rf_wr_lo      (rf_wr_lo),
    .rf_wr_hi      (rf_wr_hi),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_err   (mem_rsp_err),
    .mem_rdata     (mem_rdata),
    .busy          (busy),
    .cmp_valid     (cmp_valid),
    .exc_valid     (exc_valid),
    .exc_cause     (exc_cause),
    .exc_addr      (exc_addr),
    .exc_ack       (exc_ack)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [31:0] reg_val(input logic [4:0] idx);
    return (idx == 5'd0) ? 32'h0 : (32'h4000_0000 + 32'(idx) * 32'h0001_0010);
  endfunction

  function automatic logic [31:0] mem_val(input logic [31:0] a);
    return a ^ 32'hC3C3_3C3C;
  endfunction

  function automatic logic [31:0] sext12(input logic [11:0] v);
    return {{20{v[11]}}, v};
  endfunction

  assign rf_ra_data = reg_val(rf_ra_addr);
  assign rf_rb_data = reg_val(rf_rb_addr);
  assign mem_rdata  = mem_val(mem_addr);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Memory model and logger
  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    mem_rsp_err   = 1'b0;
    if (rf_wr_en) begin
      wr_n++;
      wr_a  = rf_wr_addr;
      wr_lo = rf_wr_lo;
      wr_hi = rf_wr_hi;
    end
    if (mem_req) begin
      if (wait_cnt > 0) begin
        chk((mem_addr == hold_addr) && (mem_wdata == hold_wd) && (mem_we == hold_we),
            "R11", "request held while waiting", mem_addr, hold_addr);
      end
      if (wait_cnt >= lat) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_err   = err_on && (mem_addr == err_addr);
        if (tx_n < 4) begin
          tx_addr[tx_n] = mem_addr;
          tx_wd[tx_n]   = mem_wdata;
          tx_we[tx_n]   = mem_we;
        end
        tx_n++;
        wait_cnt = 0;
      end else begin
        wait_cnt++;
        hold_addr = mem_addr;
        hold_wd   = mem_wdata;
        hold_we   = mem_we;
      end
    end else begin
      wait_cnt = 0;
    end
  end

  task automatic run_case(input logic [31:0] iw, input int l, input int emode);
    logic [6:0]  opc;
    logic [2:0]  f3;
    logic        is_ld;
    logic        is_st;
    logic [4:0]  pr;
    logic [11:0] imm;
    logic        legal;
    logic [31:0] a0;
    logic [31:0] a1;
    logic        e_exc;
    logic [3:0]  e_cause;
    logic [31:0] e_addr;
    int          e_ntx;
    int          e_wr;
    string       tag;
    logic [3:0]  seen_cause;
    logic [31:0] seen_addr;
    int          t;

    opc   = iw[6:0];
    f3    = iw[14:12];
    is_ld = (opc == 7'b0000011) && (f3 == 3'b011);
    is_st = (opc == 7'b0100011) && (f3 == 3'b011);
    pr    = is_st ? iw[24:20] : iw[11:7];
    imm   = is_st ? {iw[31:25], iw[11:7]} : iw[31:20];
    legal = pair_en && (is_ld || is_st) && !pr[0];
    a0    = reg_val(iw[19:15]) + sext12(imm);
    a1    = reg_val(iw[19:15]) + sext12(imm + 12'd4);

    e_exc = 1'b0; e_cause = 4'd0; e_addr = 32'd0; e_ntx = 0; e_wr = 0;
    tag = is_st ? "R2" : "R1";
    if (!legal) begin
      e_exc = 1'b1; e_cause = 4'd2; e_addr = iw; tag = "R3";
    end else if (is_ld && (pr == 5'd0)) begin
      tag = "R6";
    end else if (a0[1:0] != 2'b00) begin
      e_exc = 1'b1; e_cause = is_st ? 4'd6 : 4'd4; e_addr = a0; tag = "R8";
    end else if (emode == 1) begin
      e_exc = 1'b1; e_cause = is_st ? 4'd7 : 4'd5; e_addr = a0; e_ntx = 1; tag = "R9";
    end else if (emode == 2) begin
      e_exc = 1'b1; e_cause = is_st ? 4'd7 : 4'd5; e_addr = a1; e_ntx = 2; tag = "R9";
    end else begin
      e_ntx = 2;
      e_wr  = is_ld ? 1 : 0;
    end

    lat      = l;
    err_on   = (emode != 0);
    err_addr = (emode == 1) ? a0 : a1;

    @(negedge clk);
    tx_n = 0;
    wr_n = 0;
    chk(ins_ready == 1'b1, "R1", "ready in idle", 32'(ins_ready), 32'd1);
    ins_valid = 1'b1;
    ins_word  = iw;
    @(negedge clk);
    ins_valid = 1'b0;
    chk(busy && !ins_ready, "R10", "busy after accept", {busy, ins_ready}, 32'b10);
    t = 0;
    while (!cmp_valid && (t < 50)) begin
      @(negedge clk);
      t++;
    end
    chk(cmp_valid == 1'b1, "R10", "completion reached", 32'(t), 32'd50);
    chk(exc_valid == e_exc, tag, "exception flag", 32'(exc_valid), 32'(e_exc));
    if (exc_valid) begin
      chk(exc_cause == e_cause, tag, "exception cause", 32'(exc_cause), 32'(e_cause));
      chk(exc_addr == e_addr, tag, "exception address", exc_addr, e_addr);
      seen_cause = exc_cause;
      seen_addr  = exc_addr;
      repeat (2) @(negedge clk);
      chk(exc_valid && (exc_cause == seen_cause) && (exc_addr == seen_addr),
          "R10", "exception held until ack", exc_addr, seen_addr);
      exc_ack = 1'b1;
      @(negedge clk);
      exc_ack = 1'b0;
    end else begin
      @(negedge clk);
    end
    @(negedge clk);
    chk(busy == 1'b0, "R10", "idle after completion", 32'(busy), 32'd0);

    chk(tx_n == e_ntx, tag, "memory transaction count", 32'(tx_n), 32'(e_ntx));
    for (int k = 0; k < e_ntx && k < tx_n && k < 2; k++) begin
      chk(tx_addr[k] == ((k == 0) ? a0 : a1), "R4", "word address",
          tx_addr[k], (k == 0) ? a0 : a1);
      chk(tx_we[k] == is_st, "R7", "write enable", 32'(tx_we[k]), 32'(is_st));
      if (is_st) begin
        chk(tx_wd[k] == ((pr == 5'd0) ? 32'd0 : reg_val((k == 0) ? pr : (pr | 5'd1))),
            "R7", "store data", tx_wd[k],
            (pr == 5'd0) ? 32'd0 : reg_val((k == 0) ? pr : (pr | 5'd1)));
      end
    end
    chk(wr_n == e_wr, e_exc ? "R9" : ((tag == "R6") ? "R6" : "R5"), "register write count",
        32'(wr_n), 32'(e_wr));
    if ((e_wr == 1) && (wr_n == 1)) begin
      chk(wr_a == pr, "R5", "write pair index", 32'(wr_a), 32'(pr));
      chk(wr_lo == mem_val(a0), "R5", "low word", wr_lo, mem_val(a0));
      chk(wr_hi == mem_val(a1), "R5", "high word", wr_hi, mem_val(a1));
    end
  endtask

  function automatic logic [31:0] mk_load(input logic [11:0] imm, input logic [4:0] rs1,
                                          input logic [4:0] rd);
    return {imm, rs1, 3'b011, rd, 7'b0000011};
  endfunction

  function automatic logic [31:0] mk_store(input logic [11:0] imm, input logic [4:0] rs1,
                                           input logic [4:0] rs2);
    return {imm[11:5], rs2, rs1, 3'b011, imm[4:0], 7'b0100011};
  endfunction

  initial begin
    #(CLK_PERIOD * 190000);
    n_fail++;
    $display("FAIL R10 watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [11:0] imms [8];
    logic [4:0]  prs  [6];
    n_tests = 0; n_fail = 0;
    tx_n = 0; wr_n = 0; wait_cnt = 0; lat = 0; err_on = 1'b0; err_addr = 32'd0;
    rst_n = 1'b0; pair_en = 1'b1; ins_valid = 1'b0; ins_word = 32'd0; exc_ack = 1'b0;
    imms[0] = 12'h000; imms[1] = 12'h004; imms[2] = 12'hFFC; imms[3] = 12'h7FC;
    imms[4] = 12'h7F8; imms[5] = 12'h800; imms[6] = 12'h002; imms[7] = 12'h7FF;
    prs[0] = 5'd0; prs[1] = 5'd1; prs[2] = 5'd2; prs[3] = 5'd6; prs[4] = 5'd30; prs[5] = 5'd31;

    repeat (3) @(negedge clk);
    chk(!busy && !mem_req && !cmp_valid && !rf_wr_en, "R10", "outputs in reset",
        {busy, mem_req, cmp_valid, rf_wr_en}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(ins_ready && !busy && !mem_req && !exc_valid, "R10", "state after reset",
        {ins_ready, busy, mem_req, exc_valid}, 32'b1000);

    for (int op = 0; op < 2; op++) begin
      for (int pi = 0; pi < 6; pi++) begin
        for (int ii = 0; ii < 8; ii++) begin
          for (int l = 0; l < 3; l++) begin
            for (int em = 0; em < 3; em++) begin
              logic [4:0] rs1;
              rs1 = 5'((32'(prs[pi]) * 3 + 5 + ii) % 32);
              if (op == 0) run_case(mk_load(imms[ii], rs1, prs[pi]), l, em);
              else         run_case(mk_store(imms[ii], rs1, prs[pi]), l, em);
            end
          end
        end
      end
    end

    // R3: disabled extension, wrong funct3, wrong opcode
    pair_en = 1'b0;
    run_case(mk_load(12'h010, 5'd3, 5'd4), 0, 0);
    run_case(mk_store(12'h010, 5'd3, 5'd4), 1, 0);
    pair_en = 1'b1;
    run_case({12'h010, 5'd3, 3'b010, 5'd4, 7'b0000011}, 0, 0);
    run_case({7'd0, 5'd4, 5'd3, 3'b011, 5'd0, 7'b0110011}, 0, 0);
    run_case(mk_load(12'h010, 5'd3, 5'd4), 2, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule